// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Switchover

This block supervises a primary system clock with an always-running internal reference clock. It divides the reference by a parameter (64 by default) to form a slow sample clock. A falling edge of the monitored clock marks the current sample window as "seen". A rising edge of the sample clock opens a fresh window. On each falling edge of the sample clock the block checks that window. If the window holds no monitored edge, the primary clock is taken to have stopped.

On a detected failure the block does four things. It moves the system clock selection to the internal source and raises a sticky oscillator-fail interrupt flag. It sends a single-cycle clear pulse to the watchdog timer and its postscaler. It then enters a fail-safe condition. The visible "primary running" status bit keeps its old value in that condition, so status does not reveal the switch. Only a reset or a power-managed-mode entry strobe ends the fail-safe condition. After either event the block waits for the primary-ready indication, selects the primary clock again and resumes monitoring.

After reset the internal source is selected until the primary-ready input asserts. If it never asserts, the block stays on the internal source indefinitely. The block cannot detect a failure of the reference clock itself.

Top module: `fscm_top`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, clk_sel is 0 (0 = internal source, 1 = primary), prim_running is 0, failsafe is 0, osc_fail_irq is 0 and wdt_clear is 0.
- R2: While prim_ready is low after reset, clk_sel and prim_running stay 0. Once prim_ready is high, both become 1 within 8 ref_clk cycles. clk_sel is never 1 while prim_running is 0.
- R3: The sample period is DIV ref_clk cycles. A monitored clock with at least one falling edge in every DIV/2 ref_clk cycles never causes a failure. A monitored clock whose falling edges are more than 2*DIV ref_clk cycles apart causes a failure.
- R4: When enabled and on the primary clock, a monitored clock that stops is detected within 3*DIV+16 ref_clk cycles. failsafe then goes to 1 and clk_sel to 0, and clk_sel stays 0 for as long as failsafe is 1.
- R5: osc_fail_irq goes to 1 in the same cycle that failsafe rises. It stays 1 until a one-cycle irq_clear strobe clears it. If a failure and a clear occur together, the flag stays set.
- R6: wdt_clear pulses high for exactly one ref_clk cycle on each entry to fail-safe, and at no other time.
- R7: prim_running does not change when fail-safe is entered and stays unchanged while failsafe is 1.
- R8: With enable low, a stopped monitored clock causes no failure, and clk_sel stays on the primary clock.
- R9: failsafe, once set, stays set until pm_enter or reset. pm_enter while not in fail-safe has no effect on clk_sel, prim_running or failsafe.
- R10: No failure is declared while the internal source is still selected during start-up, even if the monitored clock is stopped.
- R11: A pm_enter strobe in fail-safe clears failsafe and clears prim_running. With prim_ready high, the primary clock is selected again within 8 cycles, and monitoring resumes so that a later failure is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Internal reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Primary clock under supervision |
| enable | input | 1 | Monitor and switchover enable |
| prim_ready | input | 1 | Primary oscillator ready (asynchronous) |
| pm_enter | input | 1 | Power-managed-mode entry strobe, one ref_clk cycle |
| irq_clear | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| clk_sel | output | 1 | System clock select, 1 = primary, 0 = internal |
| prim_running | output | 1 | Visible status: primary clock in use |
| failsafe | output | 1 | Fail-safe condition active |
| osc_fail_irq | output | 1 | Sticky oscillator-fail interrupt flag |
| wdt_clear | output | 1 | One-cycle reset pulse for watchdog and postscaler |

## Verification
The monitored clock is driven with four patterns. A fast clock and a slow clock that still lands an edge in every window must both leave the block on the primary source; these two patterns separate a working window from one that is too narrow or cleared in the wrong place. A clock slower than the sample period and a fully stopped clock must both trip the monitor; these two show that detection depends on edges arriving in each window and not merely on some activity. The stopped pattern is repeated with enable low and during start-up, which shows that the gating conditions really suppress detection.

// File: rtl/fscm_pkg.sv
`timescale 1ns/1ps
package fscm_pkg;

    typedef enum logic [1:0] {
        FS_BOOT     = 2'd0,
        FS_PRIMARY  = 2'd1,
        FS_FAILSAFE = 2'd2
    } fs_mode_e;

    typedef struct packed {
        fs_mode_e mode;
        logic     clk_sel;
        logic     prim_running;
        logic     irq;
        logic     wdt_pulse;
        logic     seen;
        logic     armed;
        logic     tog_last;
    } fs_ctrl_t;

endpackage

// File: rtl/fscm_sync.sv
`timescale 1ns/1ps
module fscm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fscm_mon_toggle.sv
`timescale 1ns/1ps
module fscm_mon_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tog
);
    logic tog_d, tog_q;

    always_comb tog_d = ~tog_q;

    always_ff @(negedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog = tog_q;
endmodule

// File: rtl/fscm_divider.sv
`timescale 1ns/1ps
module fscm_divider #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic samp_rise,
    output logic samp_fall
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF  = DIV / 2;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign samp_rise = run && (cnt_q == '0);
    assign samp_fall = run && (cnt_q == HALF_C);
endmodule

// File: rtl/fscm_ctrl.sv
`timescale 1ns/1ps
module fscm_ctrl
    import fscm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ready_s,
    input  logic tog_s,
    input  logic samp_rise,
    input  logic samp_fall,
    input  logic pm_enter,
    input  logic irq_clear,
    output logic clk_sel,
    output logic prim_running,
    output logic failsafe,
    output logic osc_fail_irq,
    output logic wdt_clear
);
    fs_ctrl_t st_d, st_q;

    logic mon_edge;
    logic monitoring;
    logic fail_hit;

    always_comb begin
        mon_edge   = tog_s ^ st_q.tog_last;
        monitoring = enable && (st_q.mode == FS_PRIMARY);
        fail_hit   = monitoring && samp_fall && st_q.armed
                     && !st_q.seen && !mon_edge;

        st_d           = st_q;
        st_d.tog_last  = tog_s;
        st_d.wdt_pulse = 1'b0;

        // window flag: a new window opens on the sample rise
        if (samp_rise) st_d.seen = mon_edge;
        else           st_d.seen = st_q.seen | mon_edge;

        // a window only counts once it was opened while monitoring
        if (!monitoring)    st_d.armed = 1'b0;
        else if (samp_rise) st_d.armed = 1'b1;

        case (st_q.mode)
            FS_BOOT: begin
                st_d.clk_sel = 1'b0;
                if (ready_s) begin
                    st_d.mode         = FS_PRIMARY;
                    st_d.clk_sel      = 1'b1;
                    st_d.prim_running = 1'b1;
                end
            end
            FS_PRIMARY: begin
                if (fail_hit) begin
                    st_d.mode      = FS_FAILSAFE;
                    st_d.clk_sel   = 1'b0;
                    st_d.wdt_pulse = 1'b1;
                end
            end
            FS_FAILSAFE: begin
                st_d.clk_sel = 1'b0;
                if (pm_enter) begin
                    st_d.mode         = FS_BOOT;
                    st_d.prim_running = 1'b0;
                end
            end
            default: begin
                st_d.mode    = FS_BOOT;
                st_d.clk_sel = 1'b0;
            end
        endcase

        st_d.irq = (st_q.irq && !irq_clear) || fail_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode         <= FS_BOOT;
            st_q.clk_sel      <= 1'b0;
            st_q.prim_running <= 1'b0;
            st_q.irq          <= 1'b0;
            st_q.wdt_pulse    <= 1'b0;
            st_q.seen         <= 1'b0;
            st_q.armed        <= 1'b0;
            st_q.tog_last     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_sel      = st_q.clk_sel;
    assign prim_running = st_q.prim_running;
    assign failsafe     = (st_q.mode == FS_FAILSAFE);
    assign osc_fail_irq = st_q.irq;
    assign wdt_clear    = st_q.wdt_pulse;
endmodule

// File: rtl/fscm_top.sv
`timescale 1ns/1ps
module fscm_top #(
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic enable,
    input  logic prim_ready,
    input  logic pm_enter,
    input  logic irq_clear,
    output logic clk_sel,
    output logic prim_running,
    output logic failsafe,
    output logic osc_fail_irq,
    output logic wdt_clear
);
    logic tog_raw;
    logic tog_s;
    logic ready_s;
    logic samp_rise;
    logic samp_fall;

    fscm_mon_toggle u_tog (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .tog     (tog_raw)
    );

    fscm_sync #(.STAGES(SYNC_STAGES)) u_sync_tog (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (tog_raw),
        .q     (tog_s)
    );

    fscm_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (prim_ready),
        .q     (ready_s)
    );

    fscm_divider #(.DIV(DIV)) u_div (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .run       (enable),
        .samp_rise (samp_rise),
        .samp_fall (samp_fall)
    );

    fscm_ctrl u_ctrl (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .ready_s      (ready_s),
        .tog_s        (tog_s),
        .samp_rise    (samp_rise),
        .samp_fall    (samp_fall),
        .pm_enter     (pm_enter),
        .irq_clear    (irq_clear),
        .clk_sel      (clk_sel),
        .prim_running (prim_running),
        .failsafe     (failsafe),
        .osc_fail_irq (osc_fail_irq),
        .wdt_clear    (wdt_clear)
    );
endmodule

// File: rtl/fscm_checker.sv
`timescale 1ns/1ps
module fscm_checker (
    input logic ref_clk,
    input logic rst_n,
    input logic enable,
    input logic pm_enter,
    input logic irq_clear,
    input logic clk_sel,
    input logic prim_running,
    input logic failsafe,
    input logic osc_fail_irq,
    input logic wdt_clear
);
    assert_internal_until_ready_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !prim_running |-> !clk_sel);

    assert_internal_in_failsafe_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        failsafe |-> !clk_sel);

    assert_irq_on_entry_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(failsafe) |-> osc_fail_irq);

    assert_irq_sticky_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (osc_fail_irq && !irq_clear) |=> osc_fail_irq);

    assert_wdt_one_cycle_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_clear);

    assert_wdt_on_entry_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(failsafe) |-> wdt_clear);

    assert_wdt_only_entry_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_clear |-> $rose(failsafe));

    assert_status_hidden_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(failsafe) |-> $stable(prim_running));

    assert_enable_gate_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(failsafe) |-> $past(enable));

    assert_failsafe_sticky_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (failsafe && !pm_enter) |=> failsafe);
endmodule

bind fscm_top fscm_checker u_chk (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .pm_enter     (pm_enter),
    .irq_clear    (irq_clear),
    .clk_sel      (clk_sel),
    .prim_running (prim_running),
    .failsafe     (failsafe),
    .osc_fail_irq (osc_fail_irq),
    .wdt_clear    (wdt_clear)
);

// File: tb/tb_fscm_top.sv
`timescale 1ns/1ps
module tb_fscm_top;
    localparam int DIV = 64;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic enable = 1'b1;
    logic prim_ready = 1'b0;
    logic pm_enter = 1'b0;
    logic irq_clear = 1'b0;
    logic clk_sel, prim_running, failsafe, osc_fail_irq, wdt_clear;

    int checks = 0;
    int fails = 0;
    int wdt_pulses = 0;
    int wdt_run = 0;
    int wdt_maxrun = 0;
    bit mon_run = 1'b0;
    int mon_half = 5;
    bit done = 1'b0;

    fscm_top #(.DIV(DIV)) dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .enable(enable),
        .prim_ready(prim_ready), .pm_enter(pm_enter), .irq_clear(irq_clear),
        .clk_sel(clk_sel), .prim_running(prim_running), .failsafe(failsafe),
        .osc_fail_irq(osc_fail_irq), .wdt_clear(wdt_clear)
    );

    always #2 ref_clk = ~ref_clk;

    always begin
        if (mon_run) begin
            #(mon_half) mon_clk = ~mon_clk;
        end else begin
            #1;
        end
    end

    always @(negedge ref_clk) begin
        if (wdt_clear) begin
            if (wdt_run == 0) wdt_pulses++;
            wdt_run++;
            if (wdt_run > wdt_maxrun) wdt_maxrun = wdt_run;
        end else begin
            wdt_run = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe_pm();
        pm_enter = 1'b1; tick(1); pm_enter = 1'b0;
    endtask

    task automatic test_reset_and_boot();
        check("R1", "clk_sel in reset", clk_sel, 0);
        check("R1", "prim_running in reset", prim_running, 0);
        check("R1", "failsafe in reset", failsafe, 0);
        check("R1", "irq in reset", osc_fail_irq, 0);
        check("R1", "wdt_clear in reset", wdt_clear, 0);
        rst_n = 1'b1;
        tick(400);
        check("R2", "clk_sel while not ready", clk_sel, 0);
        check("R2", "prim_running while not ready", prim_running, 0);
        check("R10", "no failure during start-up", failsafe, 0);
        mon_half = 5; mon_run = 1'b1;
        prim_ready = 1'b1;
        tick(8);
        check("R2", "clk_sel after ready", clk_sel, 1);
        check("R2", "prim_running after ready", prim_running, 1);
    endtask

    task automatic test_running_clocks();
        tick(500);
        check("R3", "fast clock no failure", failsafe, 0);
        mon_half = 50;
        tick(600);
        check("R3", "slow clock within window no failure", failsafe, 0);
        check("R3", "slow clock keeps primary", clk_sel, 1);
        strobe_pm();
        tick(4);
        check("R9", "pm_enter outside failsafe clk_sel", clk_sel, 1);
        check("R9", "pm_enter outside failsafe status", prim_running, 1);
        check("R9", "pm_enter outside failsafe flag", failsafe, 0);
    endtask

    task automatic test_stop_detect();
        mon_run = 1'b0;
        tick(3 * DIV + 16);
        check("R4", "failsafe after stop", failsafe, 1);
        check("R4", "internal selected", clk_sel, 0);
        check("R7", "status hides switch", prim_running, 1);
        check("R5", "irq set", osc_fail_irq, 1);
        check("R6", "one wdt pulse", wdt_pulses, 1);
        check("R6", "wdt pulse width", wdt_maxrun, 1);
        tick(300);
        check("R9", "failsafe held", failsafe, 1);
        check("R7", "status still hidden", prim_running, 1);
        check("R5", "irq sticky", osc_fail_irq, 1);
        check("R6", "no extra wdt pulse", wdt_pulses, 1);
        irq_clear = 1'b1; tick(1); irq_clear = 1'b0;
        check("R5", "irq cleared", osc_fail_irq, 0);
        check("R9", "irq clear keeps failsafe", failsafe, 1);
    endtask

    task automatic test_pm_exit_and_slow();
        mon_half = 5; mon_run = 1'b1;
        tick(20);
        strobe_pm();
        tick(8);
        check("R11", "failsafe cleared by pm_enter", failsafe, 0);
        check("R11", "primary reselected", clk_sel, 1);
        check("R11", "status back", prim_running, 1);
        tick(300);
        check("R11", "no failure after resume", failsafe, 0);
        mon_half = 300;
        tick(800);
        check("R3", "too slow clock detected", failsafe, 1);
        check("R11", "second wdt pulse", wdt_pulses, 2);
        check("R5", "irq set again", osc_fail_irq, 1);
    endtask

    task automatic test_reset_exit_and_disable();
        rst_n = 1'b0; enable = 1'b0;
        tick(2);
        check("R1", "failsafe cleared by reset", failsafe, 0);
        check("R1", "irq cleared by reset", osc_fail_irq, 0);
        check("R1", "clk_sel internal in reset", clk_sel, 0);
        mon_half = 5;
        rst_n = 1'b1;
        tick(10);
        check("R2", "primary after reset", clk_sel, 1);
        mon_run = 1'b0;
        tick(400);
        check("R8", "disabled no failure", failsafe, 0);
        check("R8", "disabled keeps primary", clk_sel, 1);
        check("R8", "disabled no irq", osc_fail_irq, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        tick(3);
        test_reset_and_boot();
        test_running_clocks();
        test_stop_detect();
        test_pm_exit_and_slow();
        test_reset_exit_and_disable();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule